// File: doc/BRIEF.md
# Register-Mapped Serial Port with Status Flags

This block is a byte-wide serial port that sits on a simple register bus and talks to a remote host over an asynchronous serial pair (8N1 framing). Software sees two neighbouring byte addresses. The lower one is the data register: a write queues one character for transmission, and a read returns the most recently received character and acknowledges it. The upper one is shared. A read returns a status byte with receive and transmit flags and two sampled input pins. A write latches six control bits that drive external pins. Three of those pins are active-low and are inverted on the way out.

The transmitter has a one-byte holding register in front of its shift register. Software can therefore load the next character while the current one is still leaving the line. The receiver synchronises the line, oversamples it, confirms a start bit at mid-bit and samples each bit at its centre. Bit timing comes from a fixed clock divider and a fixed oversampling factor, both set by parameters.

Top module: `cl_serial_port`

## Requirements
- R1: After reset the status byte reads 0x44 with both sampled pins low (transmitter-ready bit 6 and transmitter-empty bit 2 set, all other flags clear). The serial output idles at 1, and every control pin sits at its inactive level: bits 5, 3 and 2 high, bits 4, 1 and 0 low.
- R2: A byte written to the data address (DATA_ADDR) is sent as one start bit of 0, eight data bits with the LSB first, and one stop bit of 1. Each bit lasts OVERSAMPLE*CLKS_PER_TICK clocks, and the line is 1 whenever nothing is being sent.
- R3: Status bit 6 (transmitter-ready) is 1 exactly when the holding register is empty. A second byte written while the first is shifting is accepted and follows it on the line.
- R4: Status bit 2 (transmitter-empty) is 1 only when the holding register is empty and the shifter is idle, and it is 0 from the cycle after an accepted write until the stop bit of the last queued byte has ended.
- R5: A data write made while bit 6 is 0 is dropped and never appears on the line, and it sets status bit 3 (transmit overrun). Bit 3 stays set until a data write is accepted, and that write clears it.
- R6: A correctly framed received character sets status bit 7 (receive-available) and is returned by a read of the data address. That read clears bit 7.
- R7: A character whose stop-bit position samples as 0 still sets bit 7 and still delivers its data. It also sets status bit 5 (framing error), which clears on a data read.
- R8: If a character completes while bit 7 is still set, status bit 4 (receive overrun) is set and the data register holds the newest character. A data read clears bit 4.
- R9: A write to the status address (DATA_ADDR+1) latches wdata bits 5..0 onto ctl_pins. Bits 5, 3 and 2 are driven inverted and bits 4, 1 and 0 are driven directly. The write leaves the status flags unchanged.
- R10: Status bit 1 reflects pin_rdy and status bit 0 reflects pin_dout.
- R11: A low pulse on ser_rx shorter than half a bit period is rejected at the mid-bit start check and delivers no character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Register address |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe; a read of the data address acknowledges the character |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current address (combinational) |
| ser_rx | input | 1 | Serial receive line, asynchronous |
| ser_tx | output | 1 | Serial transmit line |
| pin_rdy | input | 1 | External ready pin, reported in status bit 1 |
| pin_dout | input | 1 | External serial data pin, reported in status bit 0 |
| ctl_pins | output | CTL_W | Latched control outputs with per-bit polarity |

## Verification
The bench builds the block with CLKS_PER_TICK=1 and OVERSAMPLE=16, so each bit lasts 16 clocks and a full frame lasts 160. At that length every one of the 256 byte values can be received and checked, and each control word can be written. The short frame also keeps the holding-register and overrun sequences inside a few hundred cycles. With the 4-bit address and DATA_ADDR=6, the shared status/control register sits at 7.

// File: rtl/csp_pkg.sv
package csp_pkg;

   // bit positions inside the status byte (software decodes these)
   localparam int ST_RX_AVAIL = 7;
   localparam int ST_TX_READY = 6;
   localparam int ST_FRAME_ER = 5;
   localparam int ST_RX_OVR   = 4;
   localparam int ST_TX_OVR   = 3;
   localparam int ST_TX_EMPTY = 2;
   localparam int ST_PIN_RDY  = 1;
   localparam int ST_PIN_DOUT = 0;

   localparam int FRAME_BITS  = 10;   // start + 8 data + stop

   typedef enum logic [1:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_STOP
   } rx_state_t;

endpackage

// File: rtl/csp_tick_gen.sv
module csp_tick_gen #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);

   generate
      if (DIV == 1) begin : g_every_clk
         assign tick = 1'b1;
      end else begin : g_counter
         localparam int CW = $clog2(DIV);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt <= '0;
            end else if (cnt == CW'(DIV - 1)) begin
               cnt <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
         assign tick = (cnt == CW'(DIV - 1));
      end
   endgenerate

endmodule

// File: rtl/csp_tx.sv
module csp_tx
   import csp_pkg::*;
#(
   parameter int OS = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       load,
   input  logic [7:0] din,
   output logic       ready,
   output logic       empty,
   output logic       line
);

   localparam int CW = $clog2(OS);

   logic                  hold_vld;
   logic [7:0]            hold_q;
   logic                  busy;
   logic [FRAME_BITS-1:0] sh;
   logic [CW-1:0]         cnt;
   logic [3:0]            idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_vld <= 1'b0;
         hold_q   <= '0;
         busy     <= 1'b0;
         sh       <= '1;
         cnt      <= '0;
         idx      <= '0;
      end else begin
         if (!busy && hold_vld) begin
            busy     <= 1'b1;
            sh       <= {1'b1, hold_q, 1'b0};
            cnt      <= '0;
            idx      <= '0;
            hold_vld <= 1'b0;
         end else if (busy && tick) begin
            if (cnt == CW'(OS - 1)) begin
               cnt <= '0;
               if (idx == 4'(FRAME_BITS - 1)) begin
                  busy <= 1'b0;
               end else begin
                  sh  <= {1'b1, sh[FRAME_BITS-1:1]};
                  idx <= idx + 1'b1;
               end
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
         // the top only asserts load while the holding register is empty
         if (load) begin
            hold_vld <= 1'b1;
            hold_q   <= din;
         end
      end
   end

   assign ready = !hold_vld;
   assign empty = !hold_vld && !busy;
   assign line  = busy ? sh[0] : 1'b1;

endmodule

// File: rtl/csp_rx.sv
module csp_rx
   import csp_pkg::*;
#(
   parameter int OS = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       rxd_async,
   output logic       done,
   output logic [7:0] dout,
   output logic       ferr
);

   localparam int CW   = $clog2(OS);
   localparam int HALF = OS / 2;

   logic          s1, s2;
   rx_state_t     st;
   logic [CW-1:0] cnt;
   logic [2:0]    idx;
   logic [7:0]    sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1 <= 1'b1;
         s2 <= 1'b1;
      end else begin
         s1 <= rxd_async;
         s2 <= s1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= RX_IDLE;
         cnt  <= '0;
         idx  <= '0;
         sh   <= '0;
         done <= 1'b0;
         dout <= '0;
         ferr <= 1'b0;
      end else begin
         done <= 1'b0;
         if (tick) begin
            case (st)
               RX_IDLE: begin
                  if (!s2) begin
                     st  <= RX_START;
                     cnt <= '0;
                  end
               end
               RX_START: begin
                  if (cnt == CW'(HALF - 1)) begin
                     cnt <= '0;
                     idx <= '0;
                     st  <= s2 ? RX_IDLE : RX_DATA;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RX_DATA: begin
                  if (cnt == CW'(OS - 1)) begin
                     cnt <= '0;
                     sh  <= {s2, sh[7:1]};
                     if (idx == 3'd7) begin
                        st <= RX_STOP;
                     end else begin
                        idx <= idx + 1'b1;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RX_STOP: begin
                  if (cnt == CW'(OS - 1)) begin
                     cnt  <= '0;
                     done <= 1'b1;
                     dout <= sh;
                     ferr <= !s2;
                     st   <= RX_IDLE;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               default: st <= RX_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/cl_serial_port.sv
module cl_serial_port
   import csp_pkg::*;
#(
   parameter int              ADDR_W        = 4,
   parameter int              DATA_ADDR     = 6,
   parameter int              CLKS_PER_TICK = 4,
   parameter int              OVERSAMPLE    = 16,
   parameter int              CTL_W         = 6,
   parameter logic [CTL_W-1:0] CTL_INV      = 6'b101100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata,
   input  logic              ser_rx,
   output logic              ser_tx,
   input  logic              pin_rdy,
   input  logic              pin_dout,
   output logic [CTL_W-1:0]  ctl_pins
);

   localparam int STAT_ADDR = DATA_ADDR + 1;

   // elaboration-time parameter checks
   generate
      if (OVERSAMPLE < 4 || (OVERSAMPLE % 2) != 0) begin : g_bad_os
         $error("OVERSAMPLE must be even and at least 4");
      end
      if (CLKS_PER_TICK < 1) begin : g_bad_div
         $error("CLKS_PER_TICK must be at least 1");
      end
      if (CTL_W < 1 || CTL_W > 6) begin : g_bad_ctl
         $error("CTL_W must lie in 1..6; bits 7:6 are not control bits");
      end
      if (STAT_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
         $error("DATA_ADDR+1 does not fit in ADDR_W bits");
      end
   endgenerate

   logic hit_data, hit_stat;
   logic wr_data, rd_data, wr_ctl;

   assign hit_data = (addr == ADDR_W'(DATA_ADDR));
   assign hit_stat = (addr == ADDR_W'(STAT_ADDR));
   assign wr_data  = wr_en && hit_data;
   assign rd_data  = rd_en && hit_data;
   assign wr_ctl   = wr_en && hit_stat;

   logic tick;
   csp_tick_gen #(.DIV(CLKS_PER_TICK)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   logic tx_ready, tx_empty, tx_load;
   assign tx_load = wr_data && tx_ready;

   csp_tx #(.OS(OVERSAMPLE)) u_tx (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .load  (tx_load),
      .din   (wdata),
      .ready (tx_ready),
      .empty (tx_empty),
      .line  (ser_tx)
   );

   logic       rx_done, rx_fe;
   logic [7:0] rx_byte;

   csp_rx #(.OS(OVERSAMPLE)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .rxd_async (ser_rx),
      .done      (rx_done),
      .dout      (rx_byte),
      .ferr      (rx_fe)
   );

   logic [7:0]       rx_data;
   logic             rx_avail, ferr_q, rovr_q, txovr_q;
   logic [CTL_W-1:0] ctl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data  <= '0;
         rx_avail <= 1'b0;
         ferr_q   <= 1'b0;
         rovr_q   <= 1'b0;
         txovr_q  <= 1'b0;
         ctl_q    <= '0;
      end else begin
         if (rd_data) begin
            rx_avail <= 1'b0;
            ferr_q   <= 1'b0;
            rovr_q   <= 1'b0;
         end
         if (rx_done) begin
            rx_data  <= rx_byte;
            rx_avail <= 1'b1;
            if (rx_fe) begin
               ferr_q <= 1'b1;
            end
            if (rx_avail && !rd_data) begin
               rovr_q <= 1'b1;
            end
         end
         if (wr_data) begin
            txovr_q <= !tx_ready;
         end
         if (wr_ctl) begin
            ctl_q <= wdata[CTL_W-1:0];
         end
      end
   end

   logic unused_wdata_hi;
   assign unused_wdata_hi = ^wdata[7:CTL_W];

   // per-bit output polarity chosen by CTL_INV
   generate
      for (genvar i = 0; i < CTL_W; i++) begin : g_pol
         if (CTL_INV[i]) begin : g_inv
            assign ctl_pins[i] = ~ctl_q[i];
         end else begin : g_dir
            assign ctl_pins[i] = ctl_q[i];
         end
      end
   endgenerate

   logic [7:0] status;
   always_comb begin
      status              = '0;
      status[ST_RX_AVAIL] = rx_avail;
      status[ST_TX_READY] = tx_ready;
      status[ST_FRAME_ER] = ferr_q;
      status[ST_RX_OVR]   = rovr_q;
      status[ST_TX_OVR]   = txovr_q;
      status[ST_TX_EMPTY] = tx_empty;
      status[ST_PIN_RDY]  = pin_rdy;
      status[ST_PIN_DOUT] = pin_dout;
   end

   always_comb begin
      if (hit_data) begin
         rdata = rx_data;
      end else if (hit_stat) begin
         rdata = status;
      end else begin
         rdata = '0;
      end
   end

endmodule

// File: rtl/csp_checker.sv
module csp_checker #(
   parameter int               CTL_W   = 6,
   parameter logic [CTL_W-1:0] CTL_INV = 6'b101100
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_data,
   input logic             rd_data,
   input logic             wr_ctl,
   input logic [CTL_W-1:0] wdata,
   input logic             tx_ready,
   input logic             tx_empty,
   input logic             rx_avail,
   input logic             rx_done,
   input logic             txovr,
   input logic             rovr,
   input logic             ser_tx,
   input logic [CTL_W-1:0] ctl_pins
);

   p_idle_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tx_empty |-> ser_tx);

   p_empty_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tx_empty |-> tx_ready);

   p_accept_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_data && tx_ready) |=> !tx_empty);

   p_txovr_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_data && !tx_ready) |=> txovr);

   p_txovr_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_data && tx_ready) |=> (!txovr && !tx_ready));

   p_done_avail_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done |=> rx_avail);

   p_read_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data && !rx_done) |=> (!rx_avail && !rovr));

   p_overrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done && rx_avail && !rd_data) |=> rovr);

   p_ctl_latch_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctl |=> (ctl_pins == ($past(wdata) ^ CTL_INV)));

endmodule

bind cl_serial_port csp_checker #(
   .CTL_W   (CTL_W),
   .CTL_INV (CTL_INV)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_data  (wr_data),
   .rd_data  (rd_data),
   .wr_ctl   (wr_ctl),
   .wdata    (wdata[CTL_W-1:0]),
   .tx_ready (tx_ready),
   .tx_empty (tx_empty),
   .rx_avail (rx_avail),
   .rx_done  (rx_done),
   .txovr    (txovr_q),
   .rovr     (rovr_q),
   .ser_tx   (ser_tx),
   .ctl_pins (ctl_pins)
);

// File: tb/cl_serial_port_test.sv
module cl_serial_port_test;

   localparam int         CLK_P = 10;
   localparam int         OS    = 16;
   localparam int         CPT   = 1;
   localparam int         BIT   = OS * CPT;
   localparam logic [3:0] A_DAT = 4'h6;
   localparam logic [3:0] A_ST  = 4'h7;
   localparam logic [5:0] INV   = 6'b101100;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] addr = '0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       ser_rx = 1'b1;
   logic       ser_tx;
   logic       pin_rdy = 1'b0;
   logic       pin_dout = 1'b0;
   logic [5:0] ctl_pins;

   int  n_vec = 0;
   int  n_bad = 0;
   bit  finished = 1'b0;

   logic [7:0] mon_q[$];
   int         mon_bad = 0;

   always #(CLK_P / 2) clk = ~clk;

   cl_serial_port #(
      .ADDR_W        (4),
      .DATA_ADDR     (6),
      .CLKS_PER_TICK (CPT),
      .OVERSAMPLE    (OS),
      .CTL_W         (6),
      .CTL_INV       (INV)
   ) uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr     (addr),
      .wr_en    (wr_en),
      .rd_en    (rd_en),
      .wdata    (wdata),
      .rdata    (rdata),
      .ser_rx   (ser_rx),
      .ser_tx   (ser_tx),
      .pin_rdy  (pin_rdy),
      .pin_dout (pin_dout),
      .ctl_pins (ctl_pins)
   );

   task automatic chk(string req, int act, int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic bus_wr(logic [3:0] a, logic [7:0] d);
      @(negedge clk);
      addr  = a;
      wdata = d;
      wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic bus_rd(logic [3:0] a, output logic [7:0] d);
      @(negedge clk);
      addr  = a;
      rd_en = 1'b1;
      #1 d = rdata;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic rx_frame(logic [7:0] b, logic stop_v);
      @(negedge clk);
      ser_rx = 1'b0;
      repeat (BIT) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         ser_rx = b[i];
         repeat (BIT) @(negedge clk);
      end
      ser_rx = stop_v;
      repeat (BIT) @(negedge clk);
      ser_rx = 1'b1;
   endtask

   task automatic wait_frames(int n);
      int t = 0;
      while (mon_q.size() < n && t < 30 * BIT) begin
         @(negedge clk);
         t++;
      end
   endtask

   // line monitor: decodes ser_tx at bit centres
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && ser_tx === 1'b0) begin
            logic [7:0] b;
            logic       good;
            repeat (BIT / 2 - 1) @(negedge clk);
            good = (ser_tx === 1'b0);
            for (int i = 0; i < 8; i++) begin
               repeat (BIT) @(negedge clk);
               b[i] = ser_tx;
            end
            repeat (BIT) @(negedge clk);
            if (ser_tx !== 1'b1) good = 1'b0;
            if (!good) mon_bad++;
            mon_q.push_back(b);
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_vec++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] s;
      logic [7:0] d;
      logic [7:0] tx_vals[12];
      int         lows;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      bus_rd(A_ST, s);
      chk("R1 status", s, 8'h44);
      chk("R1 ser_tx idle", ser_tx, 1);
      chk("R1 ctl_pins", ctl_pins, INV);

      // R10: pin reflection, all four combinations
      for (int p = 0; p < 4; p++) begin
         pin_rdy  = p[1];
         pin_dout = p[0];
         bus_rd(A_ST, s);
         chk("R10 pins", s, 8'h44 | p);
      end
      pin_rdy  = 1'b0;
      pin_dout = 1'b0;

      // R9: every control word
      for (int v = 0; v < 64; v++) begin
         bus_wr(A_ST, {2'b11, 6'(v)});
         chk("R9 ctl_pins", ctl_pins, 6'(v) ^ INV);
      end
      bus_rd(A_ST, s);
      chk("R9 status untouched", s, 8'h44);
      bus_wr(A_ST, 8'h00);
      chk("R9 ctl back to idle", ctl_pins, INV);

      // R2: frame format over a set of patterns
      tx_vals[0] = 8'h00;
      tx_vals[1] = 8'hFF;
      tx_vals[2] = 8'h55;
      tx_vals[3] = 8'hAA;
      for (int i = 0; i < 8; i++) tx_vals[4 + i] = 8'(1 << i);
      for (int i = 0; i < 12; i++) begin
         bus_wr(A_DAT, tx_vals[i]);
         wait_frames(1);
         chk("R2 frame count", mon_q.size(), 1);
         if (mon_q.size() > 0) chk("R2 tx byte", mon_q.pop_front(), tx_vals[i]);
      end
      chk("R2 framing bits", mon_bad, 0);
      repeat (2 * BIT) @(negedge clk);

      // R3/R4/R5: holding register, empty flag, transmit overrun
      bus_wr(A_DAT, 8'h3C);
      bus_rd(A_ST, s);
      chk("R4 empty low while shifting", s[2], 0);
      chk("R3 ready while first shifts", s[6], 1);
      bus_wr(A_DAT, 8'hC3);
      bus_rd(A_ST, s);
      chk("R3 ready low with holding full", s[6], 0);
      chk("R5 no overrun on accepted write", s[3], 0);
      bus_wr(A_DAT, 8'h99);
      bus_rd(A_ST, s);
      chk("R5 overrun set", s[3], 1);
      wait_frames(2);
      chk("R3 two frames", mon_q.size(), 2);
      if (mon_q.size() > 0) chk("R3 first byte", mon_q.pop_front(), 8'h3C);
      if (mon_q.size() > 0) chk("R3 second byte", mon_q.pop_front(), 8'hC3);
      lows = 0;
      repeat (12 * BIT) begin
         @(negedge clk);
         if (ser_tx !== 1'b1) lows++;
      end
      chk("R5 dropped byte not sent", lows, 0);
      chk("R5 no extra frame", mon_q.size(), 0);
      bus_rd(A_ST, s);
      chk("R4 empty after drain", s, 8'h4C);
      bus_wr(A_DAT, 8'h7E);
      bus_rd(A_ST, s);
      chk("R5 overrun cleared", s[3], 0);
      wait_frames(1);
      if (mon_q.size() > 0) chk("R5 next byte sent", mon_q.pop_front(), 8'h7E);
      else chk("R5 next byte sent", 0, 1);
      repeat (2 * BIT) @(negedge clk);
      bus_rd(A_ST, s);
      chk("R4 idle again", s, 8'h44);

      // R6: every received byte value
      for (int v = 0; v < 256; v++) begin
         rx_frame(8'(v), 1'b1);
         bus_rd(A_ST, s);
         chk("R6 avail", s, 8'hC4);
         bus_rd(A_DAT, d);
         chk("R6 rx byte", d, v);
         bus_rd(A_ST, s);
         chk("R6 cleared by read", s, 8'h44);
      end

      // R7: framing error
      rx_frame(8'h5A, 1'b0);
      repeat (2 * BIT) @(negedge clk);
      bus_rd(A_ST, s);
      chk("R7 framing flag", s, 8'hE4);
      bus_rd(A_DAT, d);
      chk("R7 data kept", d, 8'h5A);
      bus_rd(A_ST, s);
      chk("R7 cleared by read", s, 8'h44);

      // R8: receive overrun keeps newest
      rx_frame(8'h11, 1'b1);
      rx_frame(8'h22, 1'b1);
      bus_rd(A_ST, s);
      chk("R8 overrun flag", s, 8'hD4);
      bus_rd(A_DAT, d);
      chk("R8 newest kept", d, 8'h22);
      bus_rd(A_ST, s);
      chk("R8 cleared by read", s, 8'h44);

      // R11: short low pulse rejected
      @(negedge clk);
      ser_rx = 1'b0;
      repeat (BIT / 4) @(negedge clk);
      ser_rx = 1'b1;
      repeat (2 * BIT) @(negedge clk);
      bus_rd(A_ST, s);
      chk("R11 glitch ignored", s, 8'h44);
      rx_frame(8'hE7, 1'b1);
      bus_rd(A_DAT, d);
      chk("R11 next frame intact", d, 8'hE7);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule